// File: doc/BRIEF.md
# Watchdog Timer with Selectable Timeout

This block guards software against running away. It counts a system clock enable through a fixed binary prescaler of 2^PRE_BITS enable ticks and then through a post-scaler whose length is picked by a 2-bit rate code. If software does not service the watchdog before the post-scaler runs out, the block issues a one-clock reset request to the chip's reset logic. Software services it by writing a two-byte key sequence to a service port.

The rate code is protected in normal operating modes. It can be written once, and only during a short window of bus cycles after reset. The enable is taken from a configuration input during reset and then held, so changing the configuration takes effect only at the next reset. In special modes the rate code stays writable. Requests are also held back by an inhibit bit, which is set out of reset and which software can clear.

Top module: `swdog_ratesel`

## Requirements
- R1: While `rst` is high, and in the cycle after it falls, `rateSel` is 00 and `copReset` is 0. The prescaler, post-scaler, service sequence, write lock and bus-cycle window all restart from zero.
- R2: The prescaler advances only on clocks with `eTick` high. It rolls over every 2^PRE_BITS ticks and is never cleared by a service.
- R3: Rate codes 00, 01, 10 and 11 select M = 1, 4, 16 or 64 prescaler rollovers. With no service, the request fires on the rollover that makes the post-scaler count exceed M. The timeout is therefore never shorter than M prescaler periods and at most one period longer.
- R4: `copReset` is high for exactly one clock. It rises in the cycle after the clock edge that carries the expiring rollover.
- R5: A write of 0x55 followed by a write of 0xAA clears the post-scaler. Other values written between the two do not cancel the pair. A write of 0xAA with no 0x55 before it does nothing. A pair that completes on the same edge as an expiry suppresses that expiry.
- R6: With `specialMode` low, a rate write is taken only if no earlier write was taken since reset and fewer than WINDOW (64) `eTick` cycles have passed since reset. A write that is taken locks the register, even if it carries the same value. Writes that are refused leave `rateSel` unchanged.
- R7: With `specialMode` high, rate writes are taken at any time and any number of times.
- R8: The enable is captured from `cfgEnable` while `rst` is high. When it is captured low, no request is ever issued, and later changes on `cfgEnable` have no effect until the next reset.
- R9: The inhibit bit loads the value of `specialMode` during reset. While the bit is set, no request is issued. `inhWrEn` with `inhWrData` changes the bit only while `specialMode` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| eTick | input | 1 | Bus-cycle enable that feeds the prescaler |
| cfgEnable | input | 1 | Watchdog enable, captured during reset |
| specialMode | input | 1 | High in special test or bootstrap modes |
| inhWrEn | input | 1 | Write strobe for the inhibit bit |
| inhWrData | input | 1 | New value of the inhibit bit |
| rateWrEn | input | 1 | Write strobe for the rate code |
| rateWrData | input | RATE_W | New rate code |
| svcWrEn | input | 1 | Write strobe for the service port |
| svcWrData | input | 8 | Service byte |
| copReset | output | 1 | One-clock reset request |
| rateSel | output | RATE_W | Current rate code |

## Verification
A rate write shows on `rateSel` one clock after the write edge. An expiry shows on `copReset` one clock after the edge that carries the final prescaler tick, because the request passes through one register. The bench drives all inputs just after a falling edge and advances its reference model at the following rising edge. It compares both outputs at the next falling edge, so each result is sampled in the cycle it is due. The directed cases count clocks from reset to the first pulse and compare that count with the value worked out from M, 2^PRE_BITS and the `eTick` pattern.

// File: rtl/swdog_pkg.sv
package swdog_pkg;

  parameter logic [7:0] SVC_KEY_ARM   = 8'h55;
  parameter logic [7:0] SVC_KEY_CLEAR = 8'hAA;

  typedef struct packed {
    logic svcClear;   // complete key pair seen this cycle
    logic rateLoad;   // rate code write accepted this cycle
  } swdog_strobe_t;

  typedef enum logic {
    SVC_IDLE  = 1'b0,
    SVC_ARMED = 1'b1
  } swdog_svc_e;

endpackage

// File: rtl/swdog_ctrl.sv
module swdog_ctrl
  import swdog_pkg::*;
#(
  parameter int WINDOW = 64
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          eTick,
  input  logic          cfgEnable,
  input  logic          specialMode,
  input  logic          inhWrEn,
  input  logic          inhWrData,
  input  logic          rateWrEn,
  input  logic          svcWrEn,
  input  logic [7:0]    svcWrData,
  input  logic          expire,
  output swdog_strobe_t strobes,
  output logic          copReset
);

  localparam int BUS_W = $clog2(WINDOW + 1);
  localparam logic [BUS_W-1:0] WIN_V = BUS_W'(WINDOW);

  logic             enQ;
  logic             inhQ;
  logic             lockQ;
  logic [BUS_W-1:0] busCnt;
  swdog_svc_e       svcState;
  logic             reqQ;
  logic             rateOpen;
  logic             inWindow;

  assign inWindow = busCnt < WIN_V;
  assign rateOpen = specialMode || (!lockQ && inWindow);

  always_comb begin
    strobes.rateLoad = rateWrEn && rateOpen;
    strobes.svcClear = svcWrEn && (svcWrData == SVC_KEY_CLEAR) && (svcState == SVC_ARMED);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      enQ      <= cfgEnable;
      inhQ     <= specialMode;
      lockQ    <= 1'b0;
      busCnt   <= '0;
      svcState <= SVC_IDLE;
      reqQ     <= 1'b0;
    end else begin
      if (eTick && inWindow) busCnt <= busCnt + 1'b1;
      if (strobes.rateLoad && !specialMode) lockQ <= 1'b1;
      if (inhWrEn && specialMode) inhQ <= inhWrData;
      if (svcWrEn) begin
        if (svcWrData == SVC_KEY_ARM) svcState <= SVC_ARMED;
        else if (strobes.svcClear)   svcState <= SVC_IDLE;
      end
      reqQ <= expire && enQ && !inhQ;
    end
  end

  assign copReset = reqQ;

  AST_ONE_CYCLE_REQ: assert property (@(posedge clk) disable iff (rst)
    copReset |=> !copReset); // R4

  AST_LOCK_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (lockQ && !specialMode) |-> !strobes.rateLoad); // R6

  AST_ENABLE_FROZEN: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> $stable(enQ)); // R8

  AST_BLOCKED_REQ: assert property (@(posedge clk) disable iff (rst)
    (inhQ || !enQ) |=> !copReset); // R9

endmodule

// File: rtl/swdog_dp.sv
module swdog_dp
  import swdog_pkg::*;
#(
  parameter int PRE_BITS = 15,
  parameter int RATE_W   = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              eTick,
  input  swdog_strobe_t     strobes,
  input  logic [RATE_W-1:0] rateWrData,
  output logic              expire,
  output logic [RATE_W-1:0] rateSel
);

  localparam int MAX_SHIFT = 2 * ((1 << RATE_W) - 1);
  localparam int POST_W    = MAX_SHIFT + 1;

  logic [PRE_BITS-1:0] preCnt;
  logic [POST_W-1:0]   postCnt;
  logic [RATE_W-1:0]   rateQ;
  logic [POST_W-1:0]   limit;
  logic                preTick;

  assign limit   = POST_W'(1) << {rateQ, 1'b0};
  assign preTick = eTick && (&preCnt);
  assign expire  = preTick && (postCnt >= limit) && !strobes.svcClear;

  always_ff @(posedge clk) begin
    if (rst) begin
      preCnt  <= '0;
      postCnt <= '0;
      rateQ   <= '0;
    end else begin
      if (eTick) preCnt <= preCnt + 1'b1;
      if (strobes.svcClear || expire) postCnt <= '0;
      else if (preTick)               postCnt <= postCnt + 1'b1;
      if (strobes.rateLoad) rateQ <= rateWrData;
    end
  end

  assign rateSel = rateQ;

  AST_SVC_CLEARS: assert property (@(posedge clk) disable iff (rst)
    strobes.svcClear |=> (postCnt == '0)); // R5

  AST_PRE_HOLDS: assert property (@(posedge clk) disable iff (rst)
    !eTick |=> $stable(preCnt)); // R2

  AST_RATE_STABLE: assert property (@(posedge clk) disable iff (rst)
    !strobes.rateLoad |=> $stable(rateQ)); // R6

  AST_POST_BOUND: assert property (@(posedge clk) disable iff (rst)
    (postCnt < limit) |-> !expire); // R3

endmodule

// File: rtl/swdog_ratesel.sv
module swdog_ratesel
  import swdog_pkg::*;
#(
  parameter int PRE_BITS = 15,
  parameter int RATE_W   = 2,
  parameter int WINDOW   = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              eTick,
  input  logic              cfgEnable,
  input  logic              specialMode,
  input  logic              inhWrEn,
  input  logic              inhWrData,
  input  logic              rateWrEn,
  input  logic [RATE_W-1:0] rateWrData,
  input  logic              svcWrEn,
  input  logic [7:0]        svcWrData,
  output logic              copReset,
  output logic [RATE_W-1:0] rateSel
);

  swdog_strobe_t strobes;
  logic          expire;

  swdog_ctrl #(.WINDOW(WINDOW)) u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .eTick      (eTick),
    .cfgEnable  (cfgEnable),
    .specialMode(specialMode),
    .inhWrEn    (inhWrEn),
    .inhWrData  (inhWrData),
    .rateWrEn   (rateWrEn),
    .svcWrEn    (svcWrEn),
    .svcWrData  (svcWrData),
    .expire     (expire),
    .strobes    (strobes),
    .copReset   (copReset)
  );

  swdog_dp #(.PRE_BITS(PRE_BITS), .RATE_W(RATE_W)) u_dp (
    .clk       (clk),
    .rst       (rst),
    .eTick     (eTick),
    .strobes   (strobes),
    .rateWrData(rateWrData),
    .expire    (expire),
    .rateSel   (rateSel)
  );

endmodule

// File: tb/swdog_ratesel_tb.sv
module swdog_ratesel_tb;

  localparam int CLK_PERIOD = 10;
  localparam int PRE_BITS   = 3;
  localparam int WINDOW     = 64;
  localparam int PMAX       = (1 << PRE_BITS) - 1;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       eTick = 1'b1;
  logic       cfgEnable = 1'b1;
  logic       specialMode = 1'b0;
  logic       inhWrEn = 1'b0;
  logic       inhWrData = 1'b0;
  logic       rateWrEn = 1'b0;
  logic [1:0] rateWrData = 2'b00;
  logic       svcWrEn = 1'b0;
  logic [7:0] svcWrData = 8'h00;
  logic       copReset;
  logic [1:0] rateSel;

  int nChk = 0;
  int nFail = 0;

  // reference state, built from the requirements
  bit mEn, mInh, mLock, mArm, mReq;
  int mBus, mPre, mPost, mRate;

  always #(CLK_PERIOD/2) clk = ~clk;

  swdog_ratesel #(.PRE_BITS(PRE_BITS), .RATE_W(2), .WINDOW(WINDOW)) u_dut (
    .clk(clk), .rst(rst), .eTick(eTick), .cfgEnable(cfgEnable),
    .specialMode(specialMode), .inhWrEn(inhWrEn), .inhWrData(inhWrData),
    .rateWrEn(rateWrEn), .rateWrData(rateWrData), .svcWrEn(svcWrEn),
    .svcWrData(svcWrData), .copReset(copReset), .rateSel(rateSel)
  );

  function automatic int timeoutLimit(int code);
    return 1 << (2 * code);
  endfunction

  task automatic check(bit ok, string tag, int act, int exp);
    nChk++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic modelEdge();
    bit pt, clr, ex, open;
    if (rst) begin
      mEn = cfgEnable; mInh = specialMode; mLock = 0; mBus = 0; mArm = 0;
      mPre = 0; mPost = 0; mRate = 0; mReq = 0;
    end else begin
      pt   = eTick && (mPre == PMAX);
      clr  = svcWrEn && (svcWrData == 8'hAA) && mArm;
      ex   = pt && (mPost >= timeoutLimit(mRate)) && !clr;
      open = specialMode || (!mLock && mBus < WINDOW);
      mReq = ex && mEn && !mInh;
      if (clr || ex) mPost = 0;
      else if (pt) mPost++;
      if (eTick) mPre = (mPre + 1) & PMAX;
      if (eTick && mBus < WINDOW) mBus++;
      if (rateWrEn && open) begin
        mRate = rateWrData;
        if (!specialMode) mLock = 1;
      end
      if (inhWrEn && specialMode) mInh = inhWrData;
      if (svcWrEn) begin
        if (svcWrData == 8'h55) mArm = 1;
        else if (clr) mArm = 0;
      end
    end
  endtask

  // one clock: model at the rising edge, compare at the falling edge
  task automatic step(string tag);
    @(posedge clk);
    modelEdge();
    @(negedge clk);
    check(copReset == mReq, tag, copReset, mReq);
    check(rateSel == 2'(mRate), tag, rateSel, mRate);
    rateWrEn = 0; svcWrEn = 0; inhWrEn = 0;
  endtask

  task automatic doReset(bit en, bit spec);
    cfgEnable = en; specialMode = spec; rst = 1; eTick = 1;
    step("R1");
    step("R1");
    rst = 0;
  endtask

  task automatic countToPulse(int maxSteps, string tag, output int n);
    n = -1;
    for (int i = 1; i <= maxSteps; i++) begin
      step(tag);
      if (copReset) begin n = i; break; end
    end
  endtask

  task automatic noPulseFor(int steps, string tag);
    int seen = 0;
    for (int i = 0; i < steps; i++) begin
      step(tag);
      if (copReset) seen++;
    end
    check(seen == 0, tag, seen, 0);
  endtask

  task automatic service(logic [7:0] d, string tag);
    svcWrEn = 1; svcWrData = d;
    step(tag);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
    $finish;
  end

  initial begin
    int n;
    void'($urandom(32'd2718));
    rst = 1;
    @(negedge clk);

    // R1: reset state
    doReset(1, 0);
    check(rateSel == 2'b00, "R1", rateSel, 0);
    check(copReset == 1'b0, "R1", copReset, 0);

    // R3 + R4: code 00 fires after (1+1)*8 ticks, then drops
    countToPulse(100, "R3", n);
    check(n == 16, "R3", n, 16);
    step("R4");
    check(copReset == 1'b0, "R4", copReset, 0);

    // R3 + R6: code 01 written in first cycle, (4+1)*8 ticks
    doReset(1, 0);
    rateWrEn = 1; rateWrData = 2'b01;
    countToPulse(200, "R3", n);
    check(n == 40, "R3", n, 40);

    // R2: half-rate eTick doubles the clock count
    doReset(1, 0);
    for (int i = 1; i <= 100; i++) begin
      eTick = i[0];
      step("R2");
      if (copReset) begin n = i; break; end
    end
    eTick = 1;
    check(n == 31, "R2", n, 31);
    doReset(1, 0);
    eTick = 0;
    noPulseFor(60, "R2");
    eTick = 1;

    // R6: write once, then locked even at same value
    doReset(1, 0);
    rateWrEn = 1; rateWrData = 2'b11; step("R6");
    check(rateSel == 2'b11, "R6", rateSel, 3);
    rateWrEn = 1; rateWrData = 2'b11; step("R6");
    rateWrEn = 1; rateWrData = 2'b01; step("R6");
    check(rateSel == 2'b11, "R6", rateSel, 3);
    // R6: window boundary, 63 ticks then write is taken
    doReset(1, 0);
    for (int i = 0; i < 63; i++) step("R6");
    rateWrEn = 1; rateWrData = 2'b10; step("R6");
    check(rateSel == 2'b10, "R6", rateSel, 2);
    // R6: 64 ticks then write is refused
    doReset(1, 0);
    for (int i = 0; i < 64; i++) step("R6");
    rateWrEn = 1; rateWrData = 2'b10; step("R6");
    check(rateSel == 2'b00, "R6", rateSel, 0);

    // R5: regular key pairs keep the request away
    doReset(1, 0);
    for (int k = 0; k < 20; k++) begin
      service(8'h55, "R5"); service(8'hAA, "R5");
      noPulseFor(4, "R5");
    end
    // R5: stray byte between keys does not break the pair
    for (int k = 0; k < 20; k++) begin
      service(8'h55, "R5"); service(8'h12, "R5"); service(8'hAA, "R5");
      noPulseFor(3, "R5");
    end
    // R5: lone 0xAA does nothing
    for (int i = 1; i <= 60; i++) begin
      if (i % 3 == 0) begin svcWrEn = 1; svcWrData = 8'hAA; end
      step("R5");
      if (copReset) begin n = i; break; end
    end
    check(copReset == 1'b1, "R5", copReset, 1);

    // R8: captured disable ignores later cfgEnable
    doReset(0, 0);
    cfgEnable = 1;
    noPulseFor(80, "R8");
    doReset(1, 0);
    countToPulse(40, "R8", n);
    check(n == 16, "R8", n, 16);

    // R9 + R7: special mode starts inhibited, rate writes stay open
    doReset(1, 1);
    noPulseFor(40, "R9");
    rateWrEn = 1; rateWrData = 2'b11; step("R7");
    check(rateSel == 2'b11, "R7", rateSel, 3);
    for (int i = 0; i < 70; i++) step("R7");
    rateWrEn = 1; rateWrData = 2'b00; step("R7");
    check(rateSel == 2'b00, "R7", rateSel, 0);
    inhWrEn = 1; inhWrData = 0; step("R9");
    countToPulse(40, "R9", n);
    check(n > 0, "R9", n, 1);
    // R9: inhibit write ignored in normal mode
    doReset(1, 0);
    inhWrEn = 1; inhWrData = 1; step("R9");
    countToPulse(40, "R9", n);
    check(n == 15, "R9", n, 15);

    // random mix against the model (R3, R5, R6, R7, R9)
    for (int seg = 0; seg < 6; seg++) begin
      doReset($urandom % 4 != 0, $urandom % 3 == 0);
      for (int i = 0; i < 900; i++) begin
        int r;
        eTick = ($urandom % 4) != 0;
        if ($urandom % 3 == 0) begin
          r = $urandom % 3;
          svcWrEn = 1;
          svcWrData = (r == 0) ? 8'h55 : (r == 1) ? 8'hAA : 8'($urandom);
        end
        if ($urandom % 20 == 0) begin rateWrEn = 1; rateWrData = 2'($urandom); end
        if ($urandom % 50 == 0) begin inhWrEn = 1; inhWrData = 1'($urandom); end
        step("R3");
      end
    end

    $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
    $finish;
  end

endmodule